// File: doc/BRIEF.md
# Slaved Interlaced Raster Timing Generator

This block produces the horizontal and vertical timing of an interlaced standard-definition video encoder. It advances once per pixel-rate clock enable. A horizontal counter steps through one line and a line counter steps through one frame of two fields. A 3-bit field counter wraps every eight fields. From these counters the block decodes a line-start strobe, the field identifier, a vertical blanking flag, one multi-purpose sync output and a colour-subcarrier phase-reset pulse.

With no external sync, the counters run free. When an external trigger signal rises, the block synchronises it and preloads both counters from a programmable horizontal phase and a programmable half-line vertical phase. The preload lets the encoder follow an upstream decoder. A larger phase value moves every generated timing signal earlier. A horizontal phase of 0x398 is the usual reference value: with it, the leading edge of the analog horizontal sync falls on the trigger edge. All settings arrive on plain parallel inputs.

Top module: `raster_timer`

## Requirements
- R1: A synchronous active-low reset clears the horizontal position, the frame line and the field counter to 0. After reset, field_id is 0 and line_start is 1.
- R2: When short_line=1, h_pos counts 0..H_SHORT-1 (1716 clocks by default). When short_line=0, it counts 0..H_LONG-1 (1728 by default). It advances only on pix_en and wraps to 0. line_start is 1 exactly while h_pos is 0.
- R3: When short_line=1, a frame has F1_SHORT+F2_SHORT lines (263+262). When short_line=0, it has F1_LONG+F2_LONG lines (313+312). v_line advances when h_pos wraps. field_id is 1 when v_line is at or above the first-field length.
- R4: trig_in passes through two synchronising flops, and a rising edge is detected on the synchronised value. On the first pix_en clock at or after the detection, the counters are loaded. h_pos is loaded with min(htrig, line length-1), plus half a line when vtrig is odd. v_line is loaded with vtrig/2, plus 1 if that horizontal sum reaches the line length, in which case the sum is reduced by the line length. The result wraps modulo the frame length. The field counter is not changed by a load.
- R5: While pix_en is 0, all counters hold. A trigger edge detected during that time is remembered until the next pix_en clock.
- R6: The 3-bit field counter increments each time v_line becomes 0 or becomes the first line of the second field, and it wraps from 7 to 0.
- R7: sync_mode selects sync_port. With 00, sync_port is 1 during the first VS_LINES lines of every field. With 01, it equals field_id. With 10, it is that vertical sync pulse only in fields where the field counter is 0 (pal_seq=1) or its low two bits are 0 (pal_seq=0). With 11, it is 0.
- R8: scr_mode selects scr_reset. With 00, scr_reset equals ext_rst_req AND ext_rst_en. With 01, it is 1 while h_pos=0 on even v_line. With 10, it is 1 while h_pos=0 on the first line of a field whose field count is 0. With 11, it is the same pulse in fields whose count has low two bits 0.
- R9: With blank_std=0, vblank is 1 when the line within the field is below first_act or above last_act. With blank_std=1, vblank is 1 for the first VB_SHORT lines (short_line=1) or the first VB_LONG lines (short_line=0) of each field. The line within the field counts from 0 in both fields.
- R10: A trigger held high causes only one load. A new load needs trig_in to fall and rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_en | input | 1 | Pixel-rate clock enable |
| trig_in | input | 1 | Asynchronous external sync trigger |
| short_line | input | 1 | 1: 1716-clock lines, 525-line frame; 0: 1728 clocks, 625 lines |
| pal_seq | input | 1 | Field-sequence period: 1 eight fields, 0 four fields |
| htrig | input | HW | Horizontal preload phase |
| vtrig | input | 5 | Vertical preload phase in half-lines |
| sync_mode | input | 2 | Selects the sync_port output kind |
| scr_mode | input | 2 | Selects the subcarrier reset schedule |
| ext_rst_en | input | 1 | Enables external subcarrier reset requests |
| ext_rst_req | input | 1 | External subcarrier reset request |
| blank_std | input | 1 | 1: fixed standard blanking; 0: programmed window |
| first_act | input | VW | First active line within a field |
| last_act | input | VW | Last active line within a field |
| h_pos | output | HW | Horizontal position |
| v_line | output | VW | Line within the frame |
| line_start | output | 1 | High while h_pos is 0 |
| field_id | output | 1 | 0 first field, 1 second field |
| vblank | output | 1 | Vertical blanking flag |
| sync_port | output | 1 | Selected sync output |
| scr_reset | output | 1 | Subcarrier phase-reset pulse |

## Verification
The bench shrinks the line and field lengths so that many frames fit in a short run. For both line standards, it sweeps every sync_mode and scr_mode in combination with both field-sequence periods. Randomly gapped pix_en separates counting on enable from counting on clock. Trigger pulses held high for many cycles show the difference between edge and level response. Odd and even vtrig values and htrig values beyond the line end exercise the half-line carry, frame wrap and clamp paths. Changing the blanking window per combination shows the programmed window apart from the fixed interval.

// File: rtl/raster_pkg.sv
// Shared encodings for the raster timing generator.
// Assumes a 3-bit wrapping field counter.
package raster_pkg;
    localparam int FIELD_W = 3;

    typedef enum logic [1:0] {
        SP_VSYNC = 2'b00,
        SP_FRAME = 2'b01,
        SP_FSEQ  = 2'b10,
        SP_OFF   = 2'b11
    } sp_mode_e;

    typedef enum logic [1:0] {
        SC_EXT   = 2'b00,
        SC_LINE2 = 2'b01,
        SC_FLD8  = 2'b10,
        SC_FLD4  = 2'b11
    } sc_mode_e;

    // True in the field that starts a field-sequence period (8 or 4 fields).
    function automatic logic seq_field(input logic [FIELD_W-1:0] f, input logic eight);
        return eight ? (f == '0) : (f[1:0] == 2'b00);
    endfunction
endpackage

// File: rtl/raster_trig.sv
// Trigger synchroniser: two flops bring trig_in into the clock domain,
// a third stage detects the rising edge, and a pending flag holds an
// edge seen while pix_en is low. Assumes trig_in is asynchronous.
module raster_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic pix_en,
    output logic load_req
);
    logic s1_q, s2_q, s3_q, pend_q;
    logic rise;

    assign rise     = s2_q & ~s3_q;
    assign load_req = rise | pend_q;

    // Synchroniser chain and edge-history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= trig_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // Holds a detected edge until a pixel-enabled clock consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= load_req & ~pix_en;
    end

    // R10
    rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    // R5
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && !pix_en) |=> load_req);
endmodule

// File: rtl/raster_count.sv
// Horizontal, frame-line and field counters. Counts on pix_en, wraps at
// the end of line and frame chosen by short_line, and preloads from the
// trigger phases on load_req. Assumes vtrig/2+1 is below the frame length.
module raster_count #(
    parameter int HW       = 11,
    parameter int VW       = 10,
    parameter int TW       = 5,
    parameter int H_SHORT  = 1716,
    parameter int H_LONG   = 1728,
    parameter int F1_SHORT = 263,
    parameter int F2_SHORT = 262,
    parameter int F1_LONG  = 313,
    parameter int F2_LONG  = 312
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             pix_en,
    input  logic                             load_req,
    input  logic                             short_line,
    input  logic [HW-1:0]                    htrig,
    input  logic [TW-1:0]                    vtrig,
    output logic [HW-1:0]                    h_q,
    output logic [VW-1:0]                    v_q,
    output logic [raster_pkg::FIELD_W-1:0]   f_q
);
    localparam int FR_SHORT = F1_SHORT + F2_SHORT;
    localparam int FR_LONG  = F1_LONG + F2_LONG;

    logic [HW-1:0] h_last, h_half, h_clamp, h_ld, h_nx;
    logic [HW:0]   h_sum;
    logic [VW-1:0] v_last, f2_start, v_ld, v_nx;
    logic [VW:0]   v_sum;
    logic          carry, h_end, v_end, fstart;

    // Line and frame limits for the selected standard.
    always_comb begin
        h_last   = short_line ? HW'(H_SHORT - 1) : HW'(H_LONG - 1);
        h_half   = short_line ? HW'(H_SHORT / 2) : HW'(H_LONG / 2);
        v_last   = short_line ? VW'(FR_SHORT - 1) : VW'(FR_LONG - 1);
        f2_start = short_line ? VW'(F1_SHORT) : VW'(F1_LONG);
    end

    // Preload position from horizontal phase plus half-line vertical phase.
    always_comb begin
        h_clamp = (htrig > h_last) ? h_last : htrig;
        h_sum   = {1'b0, h_clamp} + (vtrig[0] ? {1'b0, h_half} : '0);
        carry   = h_sum > {1'b0, h_last};
        h_ld    = carry ? HW'(h_sum - ({1'b0, h_last} + 1'b1)) : h_sum[HW-1:0];
        v_sum   = (VW+1)'(vtrig[TW-1:1]) + (VW+1)'(carry);
        v_ld    = (v_sum > {1'b0, v_last}) ? VW'(v_sum - ({1'b0, v_last} + 1'b1))
                                           : v_sum[VW-1:0];
    end

    // Free-running next position and field-start detection.
    always_comb begin
        h_end  = h_q >= h_last;
        v_end  = v_q >= v_last;
        h_nx   = h_end ? '0 : h_q + 1'b1;
        v_nx   = h_end ? (v_end ? '0 : v_q + 1'b1) : v_q;
        fstart = h_end && ((v_nx == '0) || (v_nx == f2_start));
    end

    // Counter state update on each pixel enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
            v_q <= '0;
            f_q <= '0;
        end else if (pix_en) begin
            if (load_req) begin
                h_q <= h_ld;
                v_q <= v_ld;
            end else begin
                h_q <= h_nx;
                v_q <= v_nx;
                if (fstart) f_q <= f_q + 1'b1;
            end
        end
    end

    // R2
    line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !load_req && h_q == h_last) |=> h_q == '0);
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> ($stable(h_q) && $stable(v_q) && $stable(f_q)));
    // R6
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !load_req && h_q == h_last && v_q == v_last)
        |=> (v_q == '0 && f_q == raster_pkg::FIELD_W'($past(f_q) + 1'b1)));
    // R4
    preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && load_req && !vtrig[0] && htrig <= h_last) |=> h_q == $past(htrig));
endmodule

// File: rtl/raster_decode.sv
// Decodes counter state into line start, field identity, vertical
// blanking and the selectable sync output. Purely combinational;
// assumes v_line is inside the frame of the selected standard.
module raster_decode
    import raster_pkg::*;
#(
    parameter int HW       = 11,
    parameter int VW       = 10,
    parameter int F1_SHORT = 263,
    parameter int F1_LONG  = 313,
    parameter int VS_LINES = 3,
    parameter int VB_SHORT = 20,
    parameter int VB_LONG  = 25
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [HW-1:0]        h_q,
    input  logic [VW-1:0]        v_q,
    input  logic [FIELD_W-1:0]   f_q,
    input  logic                 short_line,
    input  logic                 pal_seq,
    input  logic [1:0]           sync_mode,
    input  logic                 blank_std,
    input  logic [VW-1:0]        first_act,
    input  logic [VW-1:0]        last_act,
    output logic [VW-1:0]        fld_line,
    output logic                 line_start,
    output logic                 field_id,
    output logic                 vblank,
    output logic                 sync_port
);
    logic [VW-1:0] f2_start, vb_end;
    logic          vs;

    // Line within the current field and field identity.
    always_comb begin
        f2_start   = short_line ? VW'(F1_SHORT) : VW'(F1_LONG);
        field_id   = v_q >= f2_start;
        fld_line   = field_id ? v_q - f2_start : v_q;
        line_start = h_q == '0;
        vs         = fld_line < VW'(VS_LINES);
    end

    // Vertical blanking from the programmed window or the fixed interval.
    always_comb begin
        vb_end = short_line ? VW'(VB_SHORT) : VW'(VB_LONG);
        if (blank_std) vblank = fld_line < vb_end;
        else           vblank = (fld_line < first_act) || (fld_line > last_act);
    end

    // Sync output selector.
    always_comb begin
        case (sp_mode_e'(sync_mode))
            SP_VSYNC: sync_port = vs;
            SP_FRAME: sync_port = field_id;
            SP_FSEQ:  sync_port = vs && seq_field(f_q, pal_seq);
            default:  sync_port = 1'b0;
        endcase
    end

    // R7
    off_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode == 2'b11) |-> !sync_port);
    // R7
    fseq_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode == 2'b10 && sync_port) |-> fld_line < VW'(VS_LINES));
    // R9
    std_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_std && fld_line == '0) |-> vblank);
endmodule

// File: rtl/raster_scr.sv
// Colour-subcarrier phase-reset scheduler: external request, every
// second line, or the start of every eighth or fourth field.
// Assumes the field counter wraps through all eight values.
module raster_scr
    import raster_pkg::*;
#(
    parameter int HW = 11,
    parameter int VW = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [HW-1:0]        h_q,
    input  logic [VW-1:0]        v_q,
    input  logic [VW-1:0]        fld_line,
    input  logic [FIELD_W-1:0]   f_q,
    input  logic [1:0]           scr_mode,
    input  logic                 ext_rst_en,
    input  logic                 ext_rst_req,
    output logic                 scr_reset
);
    logic at_fstart;

    // Schedule selector for the reset pulse.
    always_comb begin
        at_fstart = (h_q == '0) && (fld_line == '0);
        case (sc_mode_e'(scr_mode))
            SC_EXT:   scr_reset = ext_rst_req & ext_rst_en;
            SC_LINE2: scr_reset = (h_q == '0) && !v_q[0];
            SC_FLD8:  scr_reset = at_fstart && seq_field(f_q, 1'b1);
            default:  scr_reset = at_fstart && seq_field(f_q, 1'b0);
        endcase
    end

    // R8
    scr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scr_mode != 2'b00 && scr_reset) |-> h_q == '0);
    // R8
    scr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scr_mode == 2'b00 && !ext_rst_en) |-> !scr_reset);
endmodule

// File: rtl/raster_timer.sv
// Top of the raster timing generator: trigger synchroniser, counters,
// timing decode and subcarrier reset scheduler. Assumes all settings
// are quasi-static and a reset follows any change of short_line.
module raster_timer #(
    parameter int HW       = 11,
    parameter int VW       = 10,
    parameter int H_SHORT  = 1716,
    parameter int H_LONG   = 1728,
    parameter int F1_SHORT = 263,
    parameter int F2_SHORT = 262,
    parameter int F1_LONG  = 313,
    parameter int F2_LONG  = 312,
    parameter int VS_LINES = 3,
    parameter int VB_SHORT = 20,
    parameter int VB_LONG  = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_en,
    input  logic          trig_in,
    input  logic          short_line,
    input  logic          pal_seq,
    input  logic [HW-1:0] htrig,
    input  logic [4:0]    vtrig,
    input  logic [1:0]    sync_mode,
    input  logic [1:0]    scr_mode,
    input  logic          ext_rst_en,
    input  logic          ext_rst_req,
    input  logic          blank_std,
    input  logic [VW-1:0] first_act,
    input  logic [VW-1:0] last_act,
    output logic [HW-1:0] h_pos,
    output logic [VW-1:0] v_line,
    output logic          line_start,
    output logic          field_id,
    output logic          vblank,
    output logic          sync_port,
    output logic          scr_reset
);
    logic                               load_req;
    logic [raster_pkg::FIELD_W-1:0]     f_q;
    logic [VW-1:0]                      fld_line;

    raster_trig u_trig (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
        .pix_en(pix_en), .load_req(load_req)
    );

    raster_count #(
        .HW(HW), .VW(VW), .TW(5),
        .H_SHORT(H_SHORT), .H_LONG(H_LONG),
        .F1_SHORT(F1_SHORT), .F2_SHORT(F2_SHORT),
        .F1_LONG(F1_LONG), .F2_LONG(F2_LONG)
    ) u_count (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .load_req(load_req),
        .short_line(short_line), .htrig(htrig), .vtrig(vtrig),
        .h_q(h_pos), .v_q(v_line), .f_q(f_q)
    );

    raster_decode #(
        .HW(HW), .VW(VW), .F1_SHORT(F1_SHORT), .F1_LONG(F1_LONG),
        .VS_LINES(VS_LINES), .VB_SHORT(VB_SHORT), .VB_LONG(VB_LONG)
    ) u_decode (
        .clk(clk), .rst_n(rst_n), .h_q(h_pos), .v_q(v_line), .f_q(f_q),
        .short_line(short_line), .pal_seq(pal_seq), .sync_mode(sync_mode),
        .blank_std(blank_std), .first_act(first_act), .last_act(last_act),
        .fld_line(fld_line), .line_start(line_start), .field_id(field_id),
        .vblank(vblank), .sync_port(sync_port)
    );

    raster_scr #(.HW(HW), .VW(VW)) u_scr (
        .clk(clk), .rst_n(rst_n), .h_q(h_pos), .v_q(v_line),
        .fld_line(fld_line), .f_q(f_q), .scr_mode(scr_mode),
        .ext_rst_en(ext_rst_en), .ext_rst_req(ext_rst_req),
        .scr_reset(scr_reset)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (h_pos == '0 && v_line == '0 && !field_id));
endmodule

// File: tb/raster_timer_test.sv
// Bench: shrunk raster, sweep of every mode pair per standard, with an
// arithmetic model of the counters built from the requirements.
module raster_timer_test;
    localparam int HS = 20, HL = 24, F1S = 7, F2S = 6, F1L = 9, F2L = 8;
    localparam int VSL = 2, VBS = 3, VBL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0, pix_en = 1'b0, trig_in = 1'b0, short_line = 1'b1, pal_seq = 1'b0;
    logic [10:0] htrig = '0;
    logic [4:0]  vtrig = '0;
    logic [1:0]  sync_mode = '0, scr_mode = '0;
    logic ext_rst_en = 1'b0, ext_rst_req = 1'b0, blank_std = 1'b0;
    logic [9:0] first_act = 10'd1, last_act = 10'd5;
    logic [10:0] h_pos;
    logic [9:0]  v_line;
    logic line_start, field_id, vblank, sync_port, scr_reset;

    int checks = 0, errors = 0, k = 0;
    bit done = 0;
    int mh = 0, mv = 0, mf = 0;
    bit ms1 = 0, ms2 = 0, ms3 = 0, mpend = 0;

    always #4 clk = ~clk;

    raster_timer #(.H_SHORT(HS), .H_LONG(HL), .F1_SHORT(F1S), .F2_SHORT(F2S),
        .F1_LONG(F1L), .F2_LONG(F2L), .VS_LINES(VSL), .VB_SHORT(VBS), .VB_LONG(VBL)
    ) uut (.*);

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: got %0d expected %0d", tag, k, got, exp);
        end
    endtask

    // Model of one clock edge, from R1..R6 and R10.
    task automatic model_step();
        int hl, fr, f1, hc, hs, vn, cy;
        bit rise, req, ld;
        hl = short_line ? HS : HL;
        fr = short_line ? F1S + F2S : F1L + F2L;
        f1 = short_line ? F1S : F1L;
        if (!rst_n) begin
            mh = 0; mv = 0; mf = 0; ms1 = 0; ms2 = 0; ms3 = 0; mpend = 0;
            return;
        end
        rise = ms2 && !ms3;
        req = rise || mpend;
        ld = pix_en && req;
        mpend = req && !pix_en;
        ms3 = ms2; ms2 = ms1; ms1 = trig_in;
        if (pix_en) begin
            if (ld) begin
                hc = (int'(htrig) > hl - 1) ? hl - 1 : int'(htrig);
                hs = hc + (vtrig[0] ? hl / 2 : 0);
                cy = 0;
                if (hs >= hl) begin hs -= hl; cy = 1; end
                vn = int'(vtrig) / 2 + cy;
                if (vn >= fr) vn -= fr;
                mh = hs; mv = vn;
            end else if (mh >= hl - 1) begin
                mh = 0;
                mv = (mv >= fr - 1) ? 0 : mv + 1;
                if (mv == 0 || mv == f1) mf = (mf + 1) % 8;
            end else begin
                mh++;
            end
        end
    endtask

    // Expected decode from R2, R3, R7, R8, R9.
    task automatic compare();
        int f1, fl, vbn, e_sync, e_scr, e_vb;
        bit fid, vs, hit, fst;
        f1 = short_line ? F1S : F1L;
        fid = mv >= f1;
        fl = fid ? mv - f1 : mv;
        vs = fl < VSL;
        hit = pal_seq ? (mf == 0) : (mf % 4 == 0);
        fst = (mh == 0) && (fl == 0);
        case (sync_mode)
            2'd0: e_sync = vs;
            2'd1: e_sync = fid;
            2'd2: e_sync = vs && hit;
            default: e_sync = 0;
        endcase
        case (scr_mode)
            2'd0: e_scr = ext_rst_req && ext_rst_en;
            2'd1: e_scr = (mh == 0) && (mv % 2 == 0);
            2'd2: e_scr = fst && (mf == 0);
            default: e_scr = fst && (mf % 4 == 0);
        endcase
        vbn = short_line ? VBS : VBL;
        e_vb = blank_std ? (fl < vbn) : (fl < int'(first_act) || fl > int'(last_act));
        chk("R2 R4 R5 h_pos", int'(h_pos), mh);
        chk("R3 R4 v_line", int'(v_line), mv);
        chk("R2 line_start", int'(line_start), int'(mh == 0));
        chk("R3 field_id", int'(field_id), int'(fid));
        chk("R9 vblank", int'(vblank), e_vb);
        chk("R6 R7 sync_port", int'(sync_port), e_sync);
        chk("R6 R8 scr_reset", int'(scr_reset), e_scr);
    endtask

    // One cycle: edge, model, check away from the edge, then new stimulus.
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        k++;
        pix_en = ($urandom_range(7) != 0);          // R5 gaps
        trig_in = (k % 97) < 30;                    // R10 long high pulses
        ext_rst_req = ($urandom_range(4) == 0);
        if (k % 97 == 60) begin
            htrig = 11'($urandom_range(HL + 6));    // beyond line end: clamp, R4
            vtrig = 5'($urandom_range(31));         // odd values: half-line, R4
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", k);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int s = 1; s >= 0; s--) begin
            @(negedge clk);
            short_line = s[0];
            rst_n = 1'b0;
            repeat (2) cyc();
            rst_n = 1'b1;
            // R1: reset state observed before the first enabled count
            chk("R1 h_pos", int'(h_pos), 0);
            chk("R1 v_line", int'(v_line), 0);
            chk("R1 field_id", int'(field_id), 0);
            chk("R1 line_start", int'(line_start), 1);
            for (int p = 0; p < 2; p++) begin
                for (int sm = 0; sm < 4; sm++) begin
                    for (int cm = 0; cm < 4; cm++) begin
                        pal_seq = p[0];
                        sync_mode = 2'(sm);
                        scr_mode = 2'(cm);
                        ext_rst_en = cm[0] ^ sm[0];
                        blank_std = sm[1];
                        first_act = 10'(1 + (cm % 3));
                        last_act = 10'(5 + (cm % 3));
                        repeat (1000) cyc();
                    end
                end
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule